// File: doc/BRIEF.md
# Triggered Pattern I/O Sequencer

This block runs a 32-line parallel digital port whose lines are split into input and output lanes by a configuration field. Once armed, it waits for a start event and then enters a running phase. In that phase every pacer tick is a sample slot. In a slot, the block pushes the masked input lanes toward a capture FIFO and pops a word from a playback FIFO onto the output lanes. Samples are moved only when every active FIFO side can take part.

The start event comes from one selectable source: a software strobe, an edge on an external start line, or a pattern-match pulse. The stop event also comes from one selectable source: a software strobe, an edge on an external stop line, a pattern-match pulse, or reaching a programmed sample count. Choosing the count as the stop source gives a finite transfer. Any other stop source gives a continuous transfer.

External lines are treated as asynchronous and are synchronized inside the block. A 32-bit counter tracks the moved samples. Sticky flags report when the programmed count is reached, when a capture slot is lost, and when a playback slot is lost.

Top module: `pio_sequencer`

## Requirements
- R1: After reset the sequencer is idle (`seq_state` 0), `sample_count` is 0, all three flags are low and `pin_out` is 0.
- R2: `pin_oe` follows `cfg_port`:
  - code 0 gives 0x00000000 (all lines in);
  - code 1 gives 0xFFFFFFFF (all lines out);
  - code 2 gives 0xFFFF0000 (lines 15:0 in, 31:16 out);
  - code 3 gives 0x00FF0000 (lines 7:0 in, 23:16 out).
- R3: `di_data` equals `pin_in` ANDed with the input lanes of `cfg_port` and with the width mask. The input lanes are 0xFFFFFFFF, 0, 0x0000FFFF and 0x000000FF for codes 0 to 3. The width mask is 0xFF for `cfg_width` 0, 0xFFFF for 1, and all ones for 2 or 3. `di_data` never has a bit set on an output line.
- R4: On a clock edge where `do_pop` is high, `pin_out` takes `do_data` ANDed with the width mask. For `cfg_port` 1 the word is placed at bit 0. For codes 2 and 3 it is shifted left by 16 and ANDed with `pin_oe`. Otherwise `pin_out` holds its value.
- R5: `sw_arm` in state idle (0) or done (3) moves the sequencer to armed (1) at the next edge. It also clears `sample_count` and all three flags. In armed or running, `sw_arm` has no effect.
- R6: In armed, the start event selected by `cfg_start_src` moves the sequencer to running (2) at the next edge. Code 0 is `sw_start`, code 1 is an external start edge, code 2 is `pattern_hit`, and code 3 never starts.
- R7: External lines pass through two synchronizing flops and then an edge detector. `cfg_trig_fall`=1 selects falling edges and 0 selects rising edges. A transition driven between clock edges takes effect in the state seen after the third following rising clock edge. A held level produces no further event.
- R8: In running, the stop event selected by `cfg_stop_src` moves the sequencer to done at the next edge. Code 0 is `sw_stop`, code 1 is an external stop edge, code 2 is `pattern_hit`, and code 3 is the count condition of R12.
- R9: In armed, a selected stop event (stop codes 0 to 2) returns the sequencer to idle. It takes priority over a simultaneous start, and no sample is moved.
- R10: In running, a slot with `pacer_tick` high moves a sample when the input side is absent or `di_ready` is high and the output side is absent or `do_valid` is high. On a move, `di_push` (if inputs exist) and `do_pop` (if outputs exist) are high in that same cycle, and `sample_count` increments at the edge.
- R11: A slot that cannot move asserts neither `di_push` nor `do_pop` and leaves `sample_count` unchanged. A missing `di_ready` on an input side sets the sticky `overrun` flag. A missing `do_valid` on an output side sets the sticky `underrun` flag. Only arming clears them.
- R12: When a move brings `sample_count` equal to `cfg_count`, `count_reached` is set (sticky). With stop code 3 the sequencer enters done at that same edge. `cfg_count` must be at least 1.
- R13: Outside running, `pacer_tick` moves nothing: `di_push` and `do_pop` stay low and `sample_count` is unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_port | input | 2 | Lane direction configuration |
| cfg_width | input | 2 | Sample width select (8/16/32) |
| cfg_start_src | input | 2 | Start source select |
| cfg_stop_src | input | 2 | Stop source select |
| cfg_trig_fall | input | 1 | External trigger edge: 1 falling, 0 rising |
| cfg_count | input | 32 | Sample count target |
| sw_arm | input | 1 | Software arm strobe |
| sw_start | input | 1 | Software start strobe |
| sw_stop | input | 1 | Software stop strobe |
| ext_start | input | 1 | Asynchronous external start line |
| ext_stop | input | 1 | Asynchronous external stop line |
| pattern_hit | input | 1 | Single-cycle pattern-match pulse |
| pacer_tick | input | 1 | Sample-slot strobe |
| pin_in | input | 32 | Port lines as read |
| pin_out | output | 32 | Port output values |
| pin_oe | output | 32 | Per-line output enable |
| di_data | output | 32 | Captured word toward the capture FIFO |
| di_push | output | 1 | Capture write strobe |
| di_ready | input | 1 | Capture FIFO can accept |
| do_data | input | 32 | Playback word from the playback FIFO |
| do_valid | input | 1 | Playback FIFO holds a word |
| do_pop | output | 1 | Playback read strobe |
| seq_state | output | 2 | 0 idle, 1 armed, 2 running, 3 done |
| sample_count | output | 32 | Samples moved since arming |
| count_reached | output | 1 | Sticky: count target reached |
| overrun | output | 1 | Sticky: capture slot lost |
| underrun | output | 1 | Sticky: playback slot lost |

## Verification
`di_push`, `do_pop`, `di_data` and `pin_oe` are combinational, so they are due in the same cycle as the inputs that cause them. The bench samples them one nanosecond after it drives inputs at the falling edge. `seq_state`, `sample_count`, the flags and `pin_out` are one register away. The bench updates its own model at the rising edge and compares these outputs at the next falling edge. External trigger lines take three rising edges to change the state. The external trigger tests therefore step edge by edge and confirm that the state has not yet moved after the first and second edges, and that it has moved after the third.

// File: rtl/pio_seq_pkg.sv
// Shared encodings for the pattern I/O sequencer.
// Assumes: all selector fields are two bits wide.
package pio_seq_pkg;
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_ARMED = 2'd1,
        ST_RUN   = 2'd2,
        ST_DONE  = 2'd3
    } seq_state_e;

    localparam logic [1:0] PORT_ALL_IN  = 2'd0;
    localparam logic [1:0] PORT_ALL_OUT = 2'd1;
    localparam logic [1:0] PORT_SPLIT16 = 2'd2;
    localparam logic [1:0] PORT_SPLIT8  = 2'd3;

    localparam logic [1:0] WID_8  = 2'd0;
    localparam logic [1:0] WID_16 = 2'd1;

    localparam logic [1:0] SRC_SW  = 2'd0;
    localparam logic [1:0] SRC_EXT = 2'd1;
    localparam logic [1:0] SRC_PAT = 2'd2;
    localparam logic [1:0] SRC_CNT = 2'd3;
endpackage

// File: rtl/pio_trig_sync.sv
// Synchronizes an asynchronous trigger line and detects the selected edge.
// Produces a one-cycle event per detected edge.
// Assumes: STAGES >= 2, fall_sel is quasi-static.
module pio_trig_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic async_in,
    input  logic fall_sel,
    output logic edge_ev
);
    logic [STAGES-1:0] chain;
    logic              last_q;
    logic              synced;

    assign synced = chain[STAGES-1];

    // Shift the line through the synchronizer and keep the previous value.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            chain  <= '0;
            last_q <= 1'b0;
        end else begin
            chain  <= {chain[STAGES-2:0], async_in};
            last_q <= synced;
        end
    end

    // Compare the current and previous synchronized values for the chosen edge.
    always_comb begin
        edge_ev = fall_sel ? (last_q & ~synced) : (~last_q & synced);
    end

    // R7
    ev_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        edge_ev |=> !edge_ev);
endmodule

// File: rtl/pio_lane_map.sv
// Derives lane masks from the port configuration and shapes the data words.
// Assumes: W is a multiple of 4; split modes place outputs from bit W/2.
module pio_lane_map
    import pio_seq_pkg::*;
#(
    parameter int W = 32
) (
    input  logic [1:0]   cfg_port,
    input  logic [1:0]   cfg_width,
    input  logic [W-1:0] pin_in,
    input  logic [W-1:0] do_data,
    output logic [W-1:0] oe_mask,
    output logic [W-1:0] in_mask,
    output logic [W-1:0] in_word,
    output logic [W-1:0] out_word
);
    localparam int HALF = W / 2;
    localparam int QTR  = W / 4;
    localparam logic [W-1:0] ONES   = {W{1'b1}};
    localparam logic [W-1:0] M_QTR  = ONES >> (W - QTR);
    localparam logic [W-1:0] M_HALF = ONES >> (W - HALF);

    logic [W-1:0] wmask;
    logic [W-1:0] out_base;
    logic         shift_up;

    // Select the output-enable and input masks for the lane configuration.
    always_comb begin
        shift_up = 1'b0;
        unique case (cfg_port)
            PORT_ALL_IN: begin
                oe_mask = '0;
                in_mask = ONES;
            end
            PORT_ALL_OUT: begin
                oe_mask = ONES;
                in_mask = '0;
            end
            PORT_SPLIT16: begin
                oe_mask  = M_HALF << HALF;
                in_mask  = M_HALF;
                shift_up = 1'b1;
            end
            default: begin
                oe_mask  = M_QTR << HALF;
                in_mask  = M_QTR;
                shift_up = 1'b1;
            end
        endcase
    end

    // Select the sample-width mask.
    always_comb begin
        unique case (cfg_width)
            WID_8:   wmask = M_QTR;
            WID_16:  wmask = M_HALF;
            default: wmask = ONES;
        endcase
    end

    // Shape the capture word and the word placed on the output lanes.
    always_comb begin
        in_word  = pin_in & in_mask & wmask;
        out_base = do_data & wmask;
        out_word = (shift_up ? (out_base << HALF) : out_base) & oe_mask;
    end
endmodule

// File: rtl/pio_ctrl.sv
// Start/stop state machine, slot arbitration, sample counter and sticky flags.
// Assumes: event inputs are single-cycle pulses synchronous to clk.
module pio_ctrl
    import pio_seq_pkg::*;
#(
    parameter int CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [1:0]       cfg_start_src,
    input  logic [1:0]       cfg_stop_src,
    input  logic [CNT_W-1:0] cfg_count,
    input  logic             sw_arm,
    input  logic             sw_start,
    input  logic             sw_stop,
    input  logic             ext_start_ev,
    input  logic             ext_stop_ev,
    input  logic             pattern_hit,
    input  logic             pacer_tick,
    input  logic             has_in,
    input  logic             has_out,
    input  logic             di_ready,
    input  logic             do_valid,
    output seq_state_e       state_q,
    output logic             move,
    output logic [CNT_W-1:0] sample_count,
    output logic             count_reached,
    output logic             overrun,
    output logic             underrun
);
    seq_state_e       state_d;
    logic             start_ev;
    logic             stop_ev;
    logic             slot;
    logic             in_ok;
    logic             out_ok;
    logic             hit;
    logic             arm_ok;
    logic [CNT_W-1:0] cnt_next;

    // Pick the selected start and stop events.
    always_comb begin
        unique case (cfg_start_src)
            SRC_SW:  start_ev = sw_start;
            SRC_EXT: start_ev = ext_start_ev;
            SRC_PAT: start_ev = pattern_hit;
            default: start_ev = 1'b0;
        endcase
        unique case (cfg_stop_src)
            SRC_SW:  stop_ev = sw_stop;
            SRC_EXT: stop_ev = ext_stop_ev;
            SRC_PAT: stop_ev = pattern_hit;
            default: stop_ev = 1'b0;
        endcase
    end

    // Decide whether the current slot moves a sample.
    always_comb begin
        slot     = (state_q == ST_RUN) && pacer_tick;
        in_ok    = !has_in || di_ready;
        out_ok   = !has_out || do_valid;
        move     = slot && in_ok && out_ok;
        cnt_next = sample_count + 1'b1;
        hit      = move && (cnt_next == cfg_count);
        arm_ok   = sw_arm && ((state_q == ST_IDLE) || (state_q == ST_DONE));
    end

    // Next-state logic of the sequencer.
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:  if (sw_arm) state_d = ST_ARMED;
            ST_ARMED: begin
                if (stop_ev)       state_d = ST_IDLE;
                else if (start_ev) state_d = ST_RUN;
            end
            ST_RUN:   if (stop_ev || (hit && cfg_stop_src == SRC_CNT)) state_d = ST_DONE;
            default:  if (sw_arm) state_d = ST_ARMED;
        endcase
    end

    // State, counter and sticky flag registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q       <= ST_IDLE;
            sample_count  <= '0;
            count_reached <= 1'b0;
            overrun       <= 1'b0;
            underrun      <= 1'b0;
        end else begin
            state_q <= state_d;
            if (arm_ok) begin
                sample_count  <= '0;
                count_reached <= 1'b0;
                overrun       <= 1'b0;
                underrun      <= 1'b0;
            end else begin
                if (move) sample_count <= cnt_next;
                if (hit) count_reached <= 1'b1;
                if (slot && has_in && !di_ready) overrun <= 1'b1;
                if (slot && has_out && !do_valid) underrun <= 1'b1;
            end
        end
    end

    // R11
    cnt_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_RUN && !move) |=> $stable(sample_count));
    // R9
    armed_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_ARMED && stop_ev) |=> (state_q == ST_IDLE && sample_count == '0));
    // R5
    arm_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q != ST_ARMED) ##1 (state_q == ST_ARMED) |-> (sample_count == '0 && !overrun && !underrun));
    // R11
    overrun_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (overrun && !sw_arm) |=> overrun);
    // R12
    finite_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_stop_src == SRC_CNT && hit) |=> (state_q == ST_DONE && count_reached));
endmodule

// File: rtl/pio_sequencer.sv
// Top of the triggered pattern I/O sequencer: trigger synchronizers, lane
// mapping, control and the output pin register.
// Assumes: FIFOs outside the block; do_data is valid whenever do_valid is high.
module pio_sequencer
    import pio_seq_pkg::*;
#(
    parameter int W     = 32,
    parameter int CNT_W = 32,
    parameter int SYNC  = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [1:0]       cfg_port,
    input  logic [1:0]       cfg_width,
    input  logic [1:0]       cfg_start_src,
    input  logic [1:0]       cfg_stop_src,
    input  logic             cfg_trig_fall,
    input  logic [CNT_W-1:0] cfg_count,
    input  logic             sw_arm,
    input  logic             sw_start,
    input  logic             sw_stop,
    input  logic             ext_start,
    input  logic             ext_stop,
    input  logic             pattern_hit,
    input  logic             pacer_tick,
    input  logic [W-1:0]     pin_in,
    output logic [W-1:0]     pin_out,
    output logic [W-1:0]     pin_oe,
    output logic [W-1:0]     di_data,
    output logic             di_push,
    input  logic             di_ready,
    input  logic [W-1:0]     do_data,
    input  logic             do_valid,
    output logic             do_pop,
    output logic [1:0]       seq_state,
    output logic [CNT_W-1:0] sample_count,
    output logic             count_reached,
    output logic             overrun,
    output logic             underrun
);
    logic [W-1:0] in_mask;
    logic [W-1:0] out_word;
    logic         ext_start_ev;
    logic         ext_stop_ev;
    logic         has_in;
    logic         has_out;
    logic         move;
    seq_state_e   state_q;

    pio_trig_sync #(.STAGES(SYNC)) u_start_sync (
        .clk(clk), .rst_n(rst_n), .async_in(ext_start),
        .fall_sel(cfg_trig_fall), .edge_ev(ext_start_ev)
    );

    pio_trig_sync #(.STAGES(SYNC)) u_stop_sync (
        .clk(clk), .rst_n(rst_n), .async_in(ext_stop),
        .fall_sel(cfg_trig_fall), .edge_ev(ext_stop_ev)
    );

    pio_lane_map #(.W(W)) u_lanes (
        .cfg_port(cfg_port), .cfg_width(cfg_width), .pin_in(pin_in),
        .do_data(do_data), .oe_mask(pin_oe), .in_mask(in_mask),
        .in_word(di_data), .out_word(out_word)
    );

    pio_ctrl #(.CNT_W(CNT_W)) u_ctrl (
        .clk(clk), .rst_n(rst_n),
        .cfg_start_src(cfg_start_src), .cfg_stop_src(cfg_stop_src),
        .cfg_count(cfg_count), .sw_arm(sw_arm), .sw_start(sw_start),
        .sw_stop(sw_stop), .ext_start_ev(ext_start_ev),
        .ext_stop_ev(ext_stop_ev), .pattern_hit(pattern_hit),
        .pacer_tick(pacer_tick), .has_in(has_in), .has_out(has_out),
        .di_ready(di_ready), .do_valid(do_valid), .state_q(state_q),
        .move(move), .sample_count(sample_count),
        .count_reached(count_reached), .overrun(overrun), .underrun(underrun)
    );

    // Flag which FIFO sides take part in a slot and gate the strobes.
    always_comb begin
        has_in    = |in_mask;
        has_out   = |pin_oe;
        di_push   = move && has_in;
        do_pop    = move && has_out;
        seq_state = state_q;
    end

    // Hold the last played-back word on the output lanes.
    always_ff @(posedge clk) begin
        if (!rst_n)      pin_out <= '0;
        else if (do_pop) pin_out <= out_word;
    end

    // R3
    lanes_disjoint_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (di_data & pin_oe) == '0);
    // R13
    idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (seq_state != 2'd2) |-> (!di_push && !do_pop));
    // R4
    pin_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !do_pop |=> $stable(pin_out));
endmodule

// File: tb/sim_pio_sequencer.sv
module sim_pio_sequencer;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [1:0]  cfg_port = 0, cfg_width = 0, cfg_start_src = 0, cfg_stop_src = 0;
    logic        cfg_trig_fall = 0;
    logic [31:0] cfg_count = 32'd1;
    logic        sw_arm = 0, sw_start = 0, sw_stop = 0;
    logic        ext_start = 0, ext_stop = 0, pattern_hit = 0, pacer_tick = 0;
    logic [31:0] pin_in = 0, do_data = 0;
    logic        di_ready = 0, do_valid = 0;
    logic [31:0] pin_out, pin_oe, di_data, sample_count;
    logic        di_push, do_pop, count_reached, overrun, underrun;
    logic [1:0]  seq_state;

    int checks = 0, errors = 0;
    bit finished = 0;

    logic [1:0]  e_st;
    logic [31:0] e_cnt, e_pout;
    logic        e_hit, e_ovr, e_udr;

    always #4 clk = ~clk;

    pio_sequencer u0 (
        .clk(clk), .rst_n(rst_n), .cfg_port(cfg_port), .cfg_width(cfg_width),
        .cfg_start_src(cfg_start_src), .cfg_stop_src(cfg_stop_src),
        .cfg_trig_fall(cfg_trig_fall), .cfg_count(cfg_count), .sw_arm(sw_arm),
        .sw_start(sw_start), .sw_stop(sw_stop), .ext_start(ext_start),
        .ext_stop(ext_stop), .pattern_hit(pattern_hit), .pacer_tick(pacer_tick),
        .pin_in(pin_in), .pin_out(pin_out), .pin_oe(pin_oe), .di_data(di_data),
        .di_push(di_push), .di_ready(di_ready), .do_data(do_data),
        .do_valid(do_valid), .do_pop(do_pop), .seq_state(seq_state),
        .sample_count(sample_count), .count_reached(count_reached),
        .overrun(overrun), .underrun(underrun)
    );

    function automatic logic [31:0] f_wm(logic [1:0] w);
        return (w == 0) ? 32'h0000_00FF : (w == 1) ? 32'h0000_FFFF : 32'hFFFF_FFFF;
    endfunction
    function automatic logic [31:0] f_inm(logic [1:0] p);
        case (p)
            0: return 32'hFFFF_FFFF;
            1: return 32'h0;
            2: return 32'h0000_FFFF;
            default: return 32'h0000_00FF;
        endcase
    endfunction
    function automatic logic [31:0] f_oe(logic [1:0] p);
        case (p)
            0: return 32'h0;
            1: return 32'hFFFF_FFFF;
            2: return 32'hFFFF_0000;
            default: return 32'h00FF_0000;
        endcase
    endfunction
    function automatic logic [31:0] f_out(logic [1:0] p, logic [1:0] w, logic [31:0] d);
        if (p == 1) return d & f_wm(w);
        return ((d & f_wm(w)) << 16) & f_oe(p);
    endfunction

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h at %0t", req, act, exp, $time);
        end
    endtask

    task automatic model_reset();
        e_st = 0; e_cnt = 0; e_pout = 0; e_hit = 0; e_ovr = 0; e_udr = 0;
    endtask

    task automatic check_regs();
        check("R8 state", {30'd0, seq_state}, {30'd0, e_st});
        check("R10 count", sample_count, e_cnt);
        check("R12 reached", {31'd0, count_reached}, {31'd0, e_hit});
        check("R11 overrun", {31'd0, overrun}, {31'd0, e_ovr});
        check("R11 underrun", {31'd0, underrun}, {31'd0, e_udr});
        check("R4 pin_out", pin_out, e_pout);
    endtask

    // One modelled cycle; inputs are already driven at the falling edge. External lines held.
    task automatic step();
        logic hin, hout, mv, slot, sev, pev, hitn;
        logic [1:0] nst;
        #1;
        hin  = (f_inm(cfg_port) != 0);
        hout = (f_oe(cfg_port) != 0);
        slot = (e_st == 2) && pacer_tick;
        mv   = slot && (!hin || di_ready) && (!hout || do_valid);
        check("R2 pin_oe", pin_oe, f_oe(cfg_port));
        check("R3 di_data", di_data, pin_in & f_inm(cfg_port) & f_wm(cfg_width));
        check("R13 di_push", {31'd0, di_push}, {31'd0, mv && hin});
        check("R10 do_pop", {31'd0, do_pop}, {31'd0, mv && hout});
        sev  = (cfg_start_src == 0) ? sw_start : (cfg_start_src == 2) ? pattern_hit : 1'b0;
        pev  = (cfg_stop_src == 0) ? sw_stop : (cfg_stop_src == 2) ? pattern_hit : 1'b0;
        hitn = mv && ((e_cnt + 1) == cfg_count);
        nst  = e_st;
        case (e_st)
            0: if (sw_arm) nst = 1;
            1: if (pev) nst = 0; else if (sev) nst = 2;
            2: if (pev || (hitn && cfg_stop_src == 3)) nst = 3;
            default: if (sw_arm) nst = 1;
        endcase
        @(posedge clk);
        if ((e_st == 0 || e_st == 3) && sw_arm) begin
            e_cnt = 0; e_hit = 0; e_ovr = 0; e_udr = 0;
        end else begin
            if (mv) e_cnt = e_cnt + 1;
            if (hitn) e_hit = 1;
            if (slot && hin && !di_ready) e_ovr = 1;
            if (slot && hout && !do_valid) e_udr = 1;
        end
        if (mv && hout) e_pout = f_out(cfg_port, cfg_width, do_data);
        e_st = nst;
        @(negedge clk);
        check_regs();
    endtask

    task automatic raw_edge();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic do_reset();
        rst_n = 0;
        raw_edge(); raw_edge();
        rst_n = 1;
        model_reset();
    endtask

    initial begin
        #(8 * 150000);
        if (!finished) begin
            errors++;
            $display("FAIL watchdog: actual hung expected done");
            $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd20240611));
        @(negedge clk);
        do_reset();
        // R1 reset state
        check("R1 state", {30'd0, seq_state}, 32'd0);
        check("R1 count", sample_count, 32'd0);
        check("R1 flags", {29'd0, count_reached, overrun, underrun}, 32'd0);
        check("R1 pin_out", pin_out, 32'd0);

        // R2 direction table, explicit
        for (int p = 0; p < 4; p++) begin
            cfg_port = p[1:0];
            #1 check("R2 oe table", pin_oe, f_oe(p[1:0]));
        end

        // Constrained random transfers (sw and pattern sources, model-checked)
        for (int t = 0; t < 60; t++) begin
            cfg_port      = 2'($urandom_range(0, 3));
            cfg_width     = 2'($urandom_range(0, 3));
            cfg_start_src = ($urandom_range(0, 1) == 0) ? 2'd0 : 2'd2;
            cfg_stop_src  = 2'($urandom_range(0, 2));
            if (cfg_stop_src == 1) cfg_stop_src = 2'd3;
            cfg_count     = 32'($urandom_range(1, 10));
            for (int c = 0; c < 30; c++) begin
                sw_arm      = (c == 0) || ($urandom_range(0, 15) == 0);
                sw_start    = ($urandom_range(0, 5) == 0);
                sw_stop     = ($urandom_range(0, 19) == 0);
                pattern_hit = ($urandom_range(0, 9) == 0);
                pacer_tick  = ($urandom_range(0, 1) == 0);
                di_ready    = ($urandom_range(0, 3) != 0);
                do_valid    = ($urandom_range(0, 3) != 0);
                pin_in      = $urandom;
                do_data     = $urandom;
                step();
            end
        end
        sw_arm = 0; sw_start = 0; sw_stop = 0; pattern_hit = 0;

        // R12 finite transfer of 3 samples, all lines out, 32-bit
        do_reset();
        cfg_port = 1; cfg_width = 2; cfg_start_src = 0; cfg_stop_src = 3; cfg_count = 3;
        pacer_tick = 1; do_valid = 1; di_ready = 1;
        sw_arm = 1; step(); sw_arm = 0;
        sw_start = 1; step(); sw_start = 0;
        for (int k = 0; k < 3; k++) begin do_data = 32'hA5A5_0000 + k; step(); end
        check("R12 finite done", {30'd0, seq_state}, 32'd3);
        check("R12 finite count", sample_count, 32'd3);
        check("R4 last word", pin_out, 32'hA5A5_0002);
        step();
        check("R13 no move in done", sample_count, 32'd3);

        // R11 overrun and underrun, split 16
        cfg_port = 2; cfg_width = 1; cfg_stop_src = 0;
        sw_arm = 1; step(); sw_arm = 0;
        sw_start = 1; step(); sw_start = 0;
        di_ready = 0; do_valid = 1; step();
        check("R11 overrun set", {31'd0, overrun}, 32'd1);
        di_ready = 1; do_valid = 0; step();
        check("R11 underrun set", {31'd0, underrun}, 32'd1);
        check("R11 count held", sample_count, 32'd0);
        do_valid = 1; step(); step();
        check("R11 still sticky", {31'd0, overrun}, 32'd1);
        sw_stop = 1; step(); sw_stop = 0;

        // R9 stop while armed
        sw_arm = 1; step(); sw_arm = 0;
        sw_stop = 1; sw_start = 1; step(); sw_stop = 0; sw_start = 0;
        check("R9 back to idle", {30'd0, seq_state}, 32'd0);
        check("R9 nothing moved", sample_count, 32'd0);

        // R6 reserved start source never starts
        cfg_start_src = 3;
        sw_arm = 1; step(); sw_arm = 0;
        sw_start = 1; pattern_hit = 1; step(); step();
        sw_start = 0; pattern_hit = 0;
        check("R6 reserved stays armed", {30'd0, seq_state}, 32'd1);

        // R7 external rising start, three-edge latency
        do_reset();
        pacer_tick = 0;
        cfg_start_src = 1; cfg_stop_src = 0; cfg_trig_fall = 0;
        sw_arm = 1; step(); sw_arm = 0;
        ext_start = 1;
        raw_edge(); check("R7 edge1 armed", {30'd0, seq_state}, 32'd1);
        raw_edge(); check("R7 edge2 armed", {30'd0, seq_state}, 32'd1);
        raw_edge(); check("R7 edge3 run", {30'd0, seq_state}, 32'd2);
        e_st = 2;
        repeat (3) raw_edge();
        sw_stop = 1; step(); sw_stop = 0;
        sw_arm = 1; step(); sw_arm = 0;
        repeat (4) raw_edge();
        check("R7 held level no restart", {30'd0, seq_state}, 32'd1);
        ext_start = 0;
        repeat (4) raw_edge();

        // R8 external falling stop
        cfg_trig_fall = 1;
        ext_stop = 1;
        repeat (4) raw_edge();
        check("R8 rise ignored in fall mode", {30'd0, seq_state}, 32'd1);
        cfg_start_src = 0; cfg_stop_src = 1;
        sw_start = 1; step(); sw_start = 0;
        ext_stop = 0;
        raw_edge(); check("R8 edge1 run", {30'd0, seq_state}, 32'd2);
        raw_edge(); check("R8 edge2 run", {30'd0, seq_state}, 32'd2);
        raw_edge(); check("R8 edge3 done", {30'd0, seq_state}, 32'd3);

        finished = 1;
        $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule